// File: doc/BRIEF.md
# Sixty-Step BCD Event Divider

This block is a synchronous two-digit counter that divides a stream of qualifying events by sixty. Each cycle with the count enable high is one event. A units digit steps through the decimal values 0 to 9. A tens digit, held in three bits, steps through 0 to 5. Together they give 60 distinct states, and the pair reads directly as a decimal seconds or minutes value.

When the state wraps from 59 back to 00, a registered carry output goes high. It stays high until the next enabled cycle, so it is high for exactly one enabled cycle. Two instances can be chained by feeding the second one the AND of the first one's enable and carry. With a 60 Hz enable stream, this gives one event per second into the second stage and one event per minute out of it.

The tens stage ends its cycle early through synchronous compare logic. The incremented tens value is checked against the modulus, and the code 110 is replaced by zero before it is stored. No asynchronous clear is used.

Top module: `mod60Divider`

## Requirements
- R1: On every enabled cycle the units digit advances by one, and from 9 it returns to 0.
- R2: The units digit never shows a value above 9.
- R3: The tens digit changes only on an enabled cycle in which the units digit is 9.
- R4: The tens digit follows 0, 1, 2, 3, 4, 5 and then returns to 0; the code 6 (binary 110) never appears on it.
- R5: Bit 2 of the tens digit rises once for every six advances of the tens digit.
- R6: After the enabled cycle that moves the state from 59 to 00, carryOut is 1. The next enabled cycle clears it. On every other enabled cycle it is 0.
- R7: A stream of 60·k enable pulses, starting from reset and with any gaps between them, produces exactly k carry pulses.
- R8: A cycle with rst high leaves both digits at 0 and carryOut at 0.
- R9: A cycle with countEn low leaves both digits and carryOut unchanged.
- R10: When rst and countEn are both high in the cycle where the state is 59, reset wins. The result is 00 with no carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Event qualifier; each high cycle counts one event |
| unitsDigit | output | 4 | Units digit in BCD, 0 to 9 |
| tensDigit | output | 3 | Tens digit, 0 to 5 |
| carryOut | output | 1 | High for one enabled cycle after the wrap from 59 to 00 |

## Verification
The wrap from 59 to 00 and a synchronous reset can both land on the same clock edge. On that edge the carry-setting path and the clearing path both drive the same registers. The bench counts the state up to 59 and then raises rst and countEn together for one cycle. It then requires both digits to read zero and carryOut to stay low. The assertions also require that no enabled cycle with a state other than 59 ever leaves carryOut set.

// File: rtl/divPkg.sv
package divPkg;

  localparam int unsigned DefUnitsMod = 10;
  localparam int unsigned DefTensMod  = 6;

  typedef struct packed {
    logic clear;
    logic unitsInc;
    logic unitsWrap;
    logic tensInc;
    logic tensWrap;
    logic carryLoad;
    logic carryVal;
  } strobeT;

endpackage

// File: rtl/digitCounter.sv
module digitCounter #(
  parameter int unsigned MOD = 10,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         inc,
  input  logic         wrap,
  output logic [W-1:0] q
);

  logic [W-1:0] qNext;

  always_comb begin
    qNext = q;
    if (inc) begin
      qNext = wrap ? '0 : q + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (clear) q <= '0;
    else       q <= qNext;
  end

endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int unsigned UNITS_MOD = DefUnitsMod,
  parameter int unsigned TENS_MOD  = DefTensMod,
  parameter int unsigned UNITS_W   = $clog2(UNITS_MOD),
  parameter int unsigned TENS_W    = $clog2(TENS_MOD)
) (
  input  logic               rst,
  input  logic               countEn,
  input  logic [UNITS_W-1:0] unitsQ,
  input  logic [TENS_W-1:0]  tensQ,
  output strobeT             strobes
);

  localparam logic [UNITS_W-1:0] UnitsTop = UNITS_W'(UNITS_MOD - 1);
  localparam logic [TENS_W:0]    TensLim  = (TENS_W + 1)'(TENS_MOD);

  logic            unitsAtTop;
  logic [TENS_W:0] tensPlus;
  logic            tensHitLim;

  assign unitsAtTop = (unitsQ == UnitsTop);
  // compare the incremented tens value against the modulus so the
  // illegal code is replaced by zero before it is ever stored
  assign tensPlus   = {1'b0, tensQ} + (TENS_W + 1)'(1);
  assign tensHitLim = (tensPlus >= TensLim);

  always_comb begin
    strobes           = '0;
    strobes.clear     = rst;
    strobes.unitsInc  = countEn;
    strobes.unitsWrap = unitsAtTop;
    strobes.tensInc   = countEn & unitsAtTop;
    strobes.tensWrap  = tensHitLim;
    strobes.carryLoad = countEn;
    strobes.carryVal  = unitsAtTop & tensHitLim;
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int unsigned UNITS_MOD = DefUnitsMod,
  parameter int unsigned TENS_MOD  = DefTensMod,
  parameter int unsigned UNITS_W   = $clog2(UNITS_MOD),
  parameter int unsigned TENS_W    = $clog2(TENS_MOD)
) (
  input  logic               clk,
  input  strobeT             strobes,
  output logic [UNITS_W-1:0] unitsQ,
  output logic [TENS_W-1:0]  tensQ,
  output logic               carryQ
);

  digitCounter #(.MOD(UNITS_MOD), .W(UNITS_W)) uUnits (
    .clk   (clk),
    .clear (strobes.clear),
    .inc   (strobes.unitsInc),
    .wrap  (strobes.unitsWrap),
    .q     (unitsQ)
  );

  digitCounter #(.MOD(TENS_MOD), .W(TENS_W)) uTens (
    .clk   (clk),
    .clear (strobes.clear),
    .inc   (strobes.tensInc),
    .wrap  (strobes.tensWrap),
    .q     (tensQ)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear)          carryQ <= 1'b0;
    else if (strobes.carryLoad) carryQ <= strobes.carryVal;
  end

endmodule

// File: rtl/mod60Divider.sv
module mod60Divider
  import divPkg::*;
#(
  parameter int unsigned UNITS_MOD = DefUnitsMod,
  parameter int unsigned TENS_MOD  = DefTensMod,
  parameter int unsigned UNITS_W   = $clog2(UNITS_MOD),
  parameter int unsigned TENS_W    = $clog2(TENS_MOD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countEn,
  output logic [UNITS_W-1:0] unitsDigit,
  output logic [TENS_W-1:0]  tensDigit,
  output logic               carryOut
);

  strobeT stb;

  divControl #(
    .UNITS_MOD(UNITS_MOD), .TENS_MOD(TENS_MOD),
    .UNITS_W(UNITS_W), .TENS_W(TENS_W)
  ) uCtl (
    .rst     (rst),
    .countEn (countEn),
    .unitsQ  (unitsDigit),
    .tensQ   (tensDigit),
    .strobes (stb)
  );

  divDatapath #(
    .UNITS_MOD(UNITS_MOD), .TENS_MOD(TENS_MOD),
    .UNITS_W(UNITS_W), .TENS_W(TENS_W)
  ) uDp (
    .clk     (clk),
    .strobes (stb),
    .unitsQ  (unitsDigit),
    .tensQ   (tensDigit),
    .carryQ  (carryOut)
  );

endmodule

// File: rtl/mod60DividerChk.sv
module mod60DividerChk #(
  parameter int unsigned UNITS_MOD = 10,
  parameter int unsigned TENS_MOD  = 6,
  parameter int unsigned UNITS_W   = $clog2(UNITS_MOD),
  parameter int unsigned TENS_W    = $clog2(TENS_MOD)
) (
  input logic               clk,
  input logic               rst,
  input logic               countEn,
  input logic [UNITS_W-1:0] unitsDigit,
  input logic [TENS_W-1:0]  tensDigit,
  input logic               carryOut
);

  localparam logic [UNITS_W-1:0] UTop = UNITS_W'(UNITS_MOD - 1);
  localparam logic [TENS_W-1:0]  TTop = TENS_W'(TENS_MOD - 1);

  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  p_units_step_r1: assert property (@(posedge clk) disable iff (rst || !seenReset)
    countEn && unitsDigit != UTop |=> unitsDigit == $past(unitsDigit) + UNITS_W'(1));

  p_units_range_r2: assert property (@(posedge clk) disable iff (rst || !seenReset)
    unitsDigit <= UTop);

  p_tens_gate_r3: assert property (@(posedge clk) disable iff (rst || !seenReset)
    !(countEn && unitsDigit == UTop) |=> $stable(tensDigit));

  p_tens_range_r4: assert property (@(posedge clk) disable iff (rst || !seenReset)
    tensDigit <= TTop);

  p_carry_set_r6: assert property (@(posedge clk) disable iff (rst || !seenReset)
    countEn && unitsDigit == UTop && tensDigit == TTop |=>
      carryOut && unitsDigit == '0 && tensDigit == '0);

  p_carry_clr_r6: assert property (@(posedge clk) disable iff (rst || !seenReset)
    countEn && !(unitsDigit == UTop && tensDigit == TTop) |=> !carryOut);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> unitsDigit == '0 && tensDigit == '0 && !carryOut);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst || !seenReset)
    !countEn |=> $stable(unitsDigit) && $stable(tensDigit) && $stable(carryOut));

endmodule

bind mod60Divider mod60DividerChk #(
  .UNITS_MOD(UNITS_MOD), .TENS_MOD(TENS_MOD),
  .UNITS_W(UNITS_W), .TENS_W(TENS_W)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .countEn    (countEn),
  .unitsDigit (unitsDigit),
  .tensDigit  (tensDigit),
  .carryOut   (carryOut)
);

// File: tb/sim_mod60Divider.sv
`timescale 1ns/1ps
module sim_mod60Divider;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       countEn = 1'b0;
  logic [3:0] unitsDigit;
  logic [2:0] tensDigit;
  logic       carryOut;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  bit expCarry = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mod60Divider u0 (
    .clk(clk), .rst(rst), .countEn(countEn),
    .unitsDigit(unitsDigit), .tensDigit(tensDigit), .carryOut(carryOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    check({req, " units"}, int'(unitsDigit), expCount % 10);
    check({req, " tens"},  int'(tensDigit),  expCount / 10);
    check({req, " carry"}, int'(carryOut),   int'(expCarry));
  endtask

  // drive at the falling edge, let one rising edge pass, update model
  task automatic tick(input bit en, input bit r);
    countEn = en;
    rst = r;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      expCount = 0; expCarry = 1'b0;
    end else if (en) begin
      expCarry = (expCount == 59);
      expCount = (expCount + 1) % 60;
    end
    countEn = 1'b0;
    rst = 1'b0;
  endtask

  task automatic tReset();
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    checkAll("R8");
  endtask

  task automatic tUnitsRun();
    tReset();
    for (int i = 0; i < 25; i++) begin
      tick(1'b1, 1'b0);
      check("R1 units", int'(unitsDigit), expCount % 10);
      check("R2 range", int'(unitsDigit <= 4'd9), 1);
    end
  endtask

  task automatic tTensSequence();
    logic [2:0] prevTens;
    logic [3:0] prevUnits;
    tReset();
    for (int i = 0; i < 130; i++) begin
      prevTens  = tensDigit;
      prevUnits = unitsDigit;
      tick(1'b1, 1'b0);
      if (prevUnits != 4'd9) check("R3 tens held", int'(tensDigit), int'(prevTens));
      check("R4 tens value", int'(tensDigit), expCount / 10);
      check("R4 no code 6", int'(tensDigit != 3'd6), 1);
    end
  endtask

  task automatic tCarryWrap();
    tReset();
    for (int i = 0; i < 59; i++) tick(1'b1, 1'b0);
    checkAll("R6 at 59");
    tick(1'b1, 1'b0);
    checkAll("R6 wrap");
    check("R6 carry set", int'(carryOut), 1);
    tick(1'b1, 1'b0);
    check("R6 carry cleared", int'(carryOut), 0);
  endtask

  task automatic tHold();
    tReset();
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0);
      checkAll("R9 hold");
    end
    for (int i = 0; i < 7; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0);
      checkAll("R9 hold mid");
    end
  endtask

  task automatic tMsbRate();
    int rises = 0;
    logic prevMsb;
    tReset();
    prevMsb = tensDigit[2];
    for (int i = 0; i < 600; i++) begin
      tick(1'b1, 1'b0);
      if (tensDigit[2] && !prevMsb) rises++;
      prevMsb = tensDigit[2];
    end
    check("R5 msb rises", rises, 10);
  endtask

  task automatic tStream();
    int pulses = 0;
    logic prevCarry;
    tReset();
    prevCarry = carryOut;
    for (int i = 0; i < 900; i++) begin
      tick((i % 3) == 0, 1'b0);
      if (carryOut && !prevCarry) pulses++;
      prevCarry = carryOut;
    end
    check("R7 pulses for 300 events", pulses, 5);
    checkAll("R7 end state");
  endtask

  task automatic tResetAtWrap();
    tReset();
    for (int i = 0; i < 59; i++) tick(1'b1, 1'b0);
    check("R10 pre units", int'(unitsDigit), 9);
    check("R10 pre tens", int'(tensDigit), 5);
    tick(1'b1, 1'b1);
    checkAll("R10 reset wins");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tUnitsRun();
    tTensSequence();
    tCarryWrap();
    tHold();
    tMsbRate();
    tStream();
    tResetAtWrap();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule